// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block produces a periodic interrupt from a 16-bit down-counter. A 16-bit scale register sets a prescaler: it holds one less than the number of enabled clock cycles between two decrements of the counter. When a prescaled tick finds the counter at zero, the counter is reloaded from a 16-bit period register and a one-cycle interrupt pulse is raised. The interval between interrupts is therefore (period + 1) × (scale + 1) enabled cycles.

Software loads the scale, period and count registers through a simple one-cycle write port that selects the register with a two-bit code. The current count is always visible on a read port. An enable input freezes the timer without losing any of its state.

Top module: `interval_timer`

## Requirements
- R1: After reset the count output reads 0 and the interrupt output is low.
- R2: A write with `wr_sel` = 0 loads the scale register, 1 loads the period register and 2 loads the count register; code 3 changes nothing.
- R3: While enabled, the count drops by exactly one every scale + 1 clock cycles.
- R4: With a scale of 0 the count drops by one on every enabled cycle.
- R5: A tick that finds the count at zero reloads it from the period register; the interrupt is high for exactly that one cycle, the same cycle in which the reloaded value first appears on the count output.
- R6: With a period of 0 every prescaled tick raises the interrupt.
- R7: While `enable` is low, neither the prescaler nor the count changes and the interrupt stays low.
- R8: A count write shows on the count output one cycle later and overrides a decrement or a reload in the same cycle; such a write suppresses the interrupt.
- R9: A scale write restarts the prescaler, so the next tick comes after new scale + 1 enabled cycles, even if the write lands mid-interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Lets the prescaler and count advance |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 2 | Register select: 0 scale, 1 period, 2 count, 3 none |
| wr_data | input | 16 | Write data |
| count_out | output | 16 | Current count value |
| irq | output | 1 | One-cycle interrupt pulse on reload |

## Verification
A prescaler that runs from the wrong value shows up as a decrement of `count_out` arriving one or more cycles early or late, visible within scale + 1 enabled cycles of the disturbance. A wrong reload or a missed zero detection shows as a wrong value on `count_out` in the cycle after the zero tick, together with a missing or extra `irq` pulse. Freezing and write-priority faults appear on the very next cycle after the relevant stimulus, because every register drives a port directly or within one tick.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_out,
  output logic         irq
);

  localparam logic [1:0] SEL_SCALE  = 2'd0;
  localparam logic [1:0] SEL_PERIOD = 2'd1;
  localparam logic [1:0] SEL_COUNT  = 2'd2;

  logic [W-1:0] scale_q, period_q, count_q, pre_q;
  logic         irq_q;

  wire wr_scale  = wr_en && wr_sel == SEL_SCALE;
  wire wr_period = wr_en && wr_sel == SEL_PERIOD;
  wire wr_count  = wr_en && wr_sel == SEL_COUNT;
  wire tick      = enable && pre_q == '0;
  wire at_zero   = count_q == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q  <= '0;
      period_q <= '0;
      count_q  <= '0;
      pre_q    <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_scale)
        pre_q <= wr_data;
      else if (enable)
        pre_q <= tick ? scale_q : pre_q - 1'b1;

      if (wr_scale)  scale_q  <= wr_data;
      if (wr_period) period_q <= wr_data;

      if (wr_count)
        count_q <= wr_data;
      else if (tick)
        count_q <= at_zero ? period_q : count_q - 1'b1;

      irq_q <= tick && at_zero && !wr_count;
    end
  end

  assign count_out = count_q;
  assign irq       = irq_q;

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count_q == $past(period_q) && $past(count_q) == '0 && $past(enable)));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_en) |=> ($stable(count_q) && $stable(pre_q) && !irq));

  // R8
  count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> (count_q == $past(wr_data) && !irq));

  // R9
  prescale_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= scale_q);

  // R3
  no_early_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && pre_q != '0 && !wr_count) |=> $stable(count_q));

endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [15:0] wr_data = '0;
  logic [15:0] count_out;
  logic        irq;

  int total = 0;
  int bad = 0;

  logic [15:0] m_scale = 0, m_period = 0, m_cnt = 0, m_pre = 0;
  logic        m_irq = 0;

  always #5 clk = ~clk;

  interval_timer uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .count_out(count_out), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] cnt_exp, input logic irq_exp);
    total++;
    if (count_out !== cnt_exp || irq !== irq_exp) begin
      bad++;
      $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
               tag, count_out, irq, cnt_exp, irq_exp);
    end
  endtask

  // expected behaviour of one rising edge, from the requirements
  task automatic model_edge();
    logic t;
    t = enable && m_pre == 0;
    m_irq = 0;
    if (enable) m_pre = (m_pre == 0) ? m_scale : m_pre - 1;
    if (t) begin
      if (m_cnt == 0) begin m_cnt = m_period; m_irq = 1; end
      else m_cnt = m_cnt - 1;
    end
    if (wr_en) begin
      case (wr_sel)
        2'd0: begin m_scale = wr_data; m_pre = wr_data; end
        2'd1: m_period = wr_data;
        2'd2: begin m_cnt = wr_data; m_irq = 0; end
        default: ;
      endcase
    end
  endtask

  task automatic step(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); model_edge();
      @(negedge clk); check(tag, m_cnt, m_irq);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); model_edge();
    @(negedge clk);
    wr_en = 1'b0; wr_sel = 2'd3;
  endtask

  task automatic setup(input logic [15:0] s, input logic [15:0] p, input logic [15:0] c);
    enable = 1'b0;
    wr(2'd0, s); wr(2'd1, p); wr(2'd2, c);
  endtask

  task automatic t_reset();
    check("R1 reset", 16'd0, 1'b0);
  endtask

  task automatic t_prescale();
    setup(16'd2, 16'd100, 16'd5);
    enable = 1'b1;
    step(2, "R3 prescale wait");
    check("R3 before tick", 16'd5, 1'b0);
    step(1, "R3 tick");
    check("R3 first step", 16'd4, 1'b0);
    step(6, "R3 prescale run");
    check("R3 after nine", 16'd2, 1'b0);
  endtask

  task automatic t_fast();
    setup(16'd0, 16'd3, 16'd2);
    enable = 1'b1;
    step(2, "R4 every cycle");
    check("R4 reached zero", 16'd0, 1'b0);
    step(1, "R5 reload");
    check("R5 reload pulse", 16'd3, 1'b1);
    step(1, "R5 pulse ends");
    check("R5 single cycle", 16'd2, 1'b0);
    step(8, "R5 periodic");
  endtask

  task automatic t_period0();
    setup(16'd1, 16'd0, 16'd0);
    enable = 1'b1;
    step(2, "R6 period zero");
    check("R6 irq on tick", 16'd0, 1'b1);
    step(2, "R6 period zero");
    check("R6 irq again", 16'd0, 1'b1);
    step(4, "R6 period zero");
  endtask

  task automatic t_hold();
    setup(16'd0, 16'd40, 16'd10);
    enable = 1'b1;
    step(2, "R7 run");
    enable = 1'b0;
    step(5, "R7 frozen");
    check("R7 frozen value", 16'd8, 1'b0);
    enable = 1'b1;
    step(3, "R7 resume");
    check("R7 resumed", 16'd5, 1'b0);
  endtask

  task automatic t_override();
    setup(16'd0, 16'd50, 16'd0);
    enable = 1'b1;
    wr(2'd2, 16'd7);
    check("R8 write beats reload", 16'd7, 1'b0);
    wr(2'd2, 16'd300);
    check("R8 write beats decrement", 16'd300, 1'b0);
    step(2, "R8 continue");
  endtask

  task automatic t_sel3();
    setup(16'd1, 16'd4, 16'd9);
    wr(2'd3, 16'h1234);
    check("R2 code 3 ignored", 16'd9, 1'b0);
    enable = 1'b1;
    step(12, "R2 registers kept");
    enable = 1'b0;
  endtask

  task automatic t_scale_restart();
    setup(16'd3, 16'd60, 16'd20);
    enable = 1'b1;
    step(2, "R9 partial interval");
    wr(2'd0, 16'd1);
    check("R9 no tick on write", 16'd20, 1'b0);
    step(1, "R9 restarted");
    check("R9 restarted wait", 16'd20, 1'b0);
    step(1, "R9 new tick");
    check("R9 tick after restart", 16'd19, 1'b0);
    step(4, "R9 new rate");
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_fast();
    t_period0();
    t_hold();
    t_override();
    t_sel3();
    t_scale_restart();
    finish_run();
  end
endmodule